// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the clocked control core for one half-bridge phase of a synchronous buck converter. It takes a PWM indication that analog comparators have already classed as low, high or mid-level, and turns it into two gate-enable outputs, one for the high-side switch and one for the low-side switch. Every delay it applies is a count of local clock cycles.

Before either gate is enabled, the block waits for a "gate is low" sense flag from the opposite switch, and then for a short fixed settle count. A PWM input that stays parked at mid-level long enough turns both switches off. An active-low disable input has separate filter lengths for shutting down and for starting up. An active-low diode-emulation input makes the low side stop conducting when the inductor current reaches zero. An under-voltage flag clamps both gates low in the same cycle it is seen.

The block sits between the level comparators and the gate drivers. The sense flags come back from the driver stages.

Top module: `buck_gate_ctrl`

## Requirements
- R1: A synchronous active-low reset leaves both gate outputs low and clears every timer. After reset, switching starts only once the full start-up filter (ON_CYC samples of disable-high) has elapsed.
- R2: PWM level code `pwm_lvl`: 2'b00 is low, 2'b01 is high, 2'b1x is mid. A high level turns the low-side gate off on the next clock edge, and the high-side gate is turned on later. A low level does the reverse.
- R3: A gate is enabled only after the opposite gate's low-sense flag has been sampled true on DT_CYC consecutive edges while that gate is requested. If the flag drops, the count restarts. This also applies when leaving the parked, disabled or under-voltage condition.
- R4: `hs_gate` and `ls_gate` are never high in the same cycle.
- R5: HOLD_CYC consecutive mid samples turn both gates off on the following edge. A mid stay that is shorter than this keeps the gate state that was last commanded.
- R6: After DIS_OFF_CYC consecutive samples of `dis_n` low, both gates are low on the next edge. They stay low whatever the PWM input does.
- R7: After DIS_ON_CYC consecutive samples of `dis_n` high, switching resumes. Any sample that breaks the run restarts the filter.
- R8: With `demu_n` low and the low side on or waiting to turn on, an asserted `zc_flag` turns the low side off on the next edge. It stays off until the next high PWM level.
- R9: With `demu_n` high, the low side follows a low PWM level and `zc_flag` has no effect.
- R10: While `uvlo` is high, both gate outputs are low in the same cycle. The internal state returns to all-off and the start-up filter restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; all delays count its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_lvl | input | 2 | Classified PWM level: 00 low, 01 high, 1x mid |
| dis_n | input | 1 | Disable, active low (low when left open) |
| demu_n | input | 1 | Diode-emulation enable, active low (high when left open) |
| zc_flag | input | 1 | Inductor current has reached zero |
| uvlo | input | 1 | Supply under-voltage lockout asserted |
| hs_low_sense | input | 1 | High-side gate voltage is below its off threshold |
| ls_low_sense | input | 1 | Low-side gate voltage is below its off threshold |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The assertions check the following on every cycle:
- The two gates never overlap.
- Each gate rises only after the opposite sense flag was seen.
- A low enable or a parked PWM input leaves both gates off one edge later.
- An under-voltage sample empties the state machine.
- A zero crossing under emulation ends low-side conduction.

Other behaviour only the bench's scenarios can show. This covers the exact lengths of the hold-off and disable filters, the fact that a brief mid-level stay is harmless, that a zero-crossing cut-off lasts until the next high level, and the start-up delay after reset or lockout. These are checked against a cycle reference model driven by closed-loop sense flags.

// File: rtl/buck_gd_pkg.sv
package buck_gd_pkg;
  // Gate phases of the sequencer
  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_WAIT_HS = 3'd1,
    PH_HS      = 3'd2,
    PH_WAIT_LS = 3'd3,
    PH_LS      = 3'd4,
    PH_LS_DONE = 3'd5
  } phase_e;

  // Requested conduction side
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_HS   = 2'd1,
    CMD_LS   = 2'd2
  } cmd_e;

  localparam logic [1:0] LVL_LO = 2'b00;
  localparam logic [1:0] LVL_HI = 2'b01;
endpackage

// File: rtl/bgd_enable_filter.sv
// Asymmetric run filter on the active-low disable input.
module bgd_enable_filter #(
  parameter int OFF_CYC = 10,
  parameter int ON_CYC  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo,
  input  logic dis_n,
  output logic run
);
  localparam int MAXC = (OFF_CYC > ON_CYC) ? OFF_CYC : ON_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = run ? CW'(OFF_CYC - 1) : CW'(ON_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || uvlo) begin
      run   <= 1'b0;
      cnt_q <= '0;
    end else if (dis_n == run) begin
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      run   <= ~run;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_run_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(dis_n));
  p_run_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(!dis_n) || $past(uvlo)));
endmodule

// File: rtl/bgd_tri_holdoff.sv
// Parks the phase after a long enough stay at mid-level.
module bgd_tri_holdoff #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_mid,
  output logic parked
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !is_mid) begin
      parked <= 1'b0;
      cnt_q  <= '0;
    end else if (!parked) begin
      if (cnt_q == HW'(HOLD_CYC - 1)) begin
        parked <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_park_needs_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parked) |-> $past(is_mid));
endmodule

// File: rtl/bgd_phase_fsm.sv
// Gate sequencing with adaptive dead time and diode emulation.
module bgd_phase_fsm
  import buck_gd_pkg::*;
#(
  parameter int DT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo,
  input  logic run,
  input  logic parked,
  input  logic pwm_hi,
  input  logic pwm_lo,
  input  logic demu_en,
  input  logic zc,
  input  logic hs_low,
  input  logic ls_low,
  output logic hs_on,
  output logic ls_on
);
  localparam int DW = (DT_CYC > 1) ? $clog2(DT_CYC) : 1;

  phase_e        ph_q, ph_d;
  cmd_e          cmd_q, tgt;
  logic [DW-1:0] dt_q, dt_d;
  logic          dt_last;

  assign dt_last = (dt_q == DW'(DT_CYC - 1));

  always_comb begin
    if (!run || parked) tgt = CMD_NONE;
    else if (pwm_hi)    tgt = CMD_HS;
    else if (pwm_lo)    tgt = CMD_LS;
    else                tgt = cmd_q;
  end

  always_comb begin
    ph_d = ph_q;
    dt_d = '0;
    if (uvlo) begin
      ph_d = PH_OFF;
    end else begin
      case (ph_q)
        PH_OFF: begin
          if (tgt == CMD_HS)      ph_d = PH_WAIT_HS;
          else if (tgt == CMD_LS) ph_d = PH_WAIT_LS;
        end
        PH_WAIT_HS: begin
          if (tgt != CMD_HS) ph_d = (tgt == CMD_LS) ? PH_WAIT_LS : PH_OFF;
          else if (ls_low) begin
            if (dt_last) ph_d = PH_HS;
            else         dt_d = dt_q + 1'b1;
          end
        end
        PH_HS: begin
          if (tgt == CMD_LS)        ph_d = PH_WAIT_LS;
          else if (tgt == CMD_NONE) ph_d = PH_OFF;
        end
        PH_WAIT_LS: begin
          if (tgt != CMD_LS) ph_d = (tgt == CMD_HS) ? PH_WAIT_HS : PH_OFF;
          else if (demu_en && zc) ph_d = PH_LS_DONE;
          else if (hs_low) begin
            if (dt_last) ph_d = PH_LS;
            else         dt_d = dt_q + 1'b1;
          end
        end
        PH_LS: begin
          if (tgt == CMD_HS)        ph_d = PH_WAIT_HS;
          else if (tgt == CMD_NONE) ph_d = PH_OFF;
          else if (demu_en && zc)   ph_d = PH_LS_DONE;
        end
        PH_LS_DONE: begin
          if (tgt == CMD_HS)        ph_d = PH_WAIT_HS;
          else if (tgt == CMD_NONE) ph_d = PH_OFF;
        end
        default: ph_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      cmd_q <= CMD_NONE;
      dt_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      cmd_q <= uvlo ? CMD_NONE : tgt;
      dt_q  <= dt_d;
    end
  end

  assign hs_on = (ph_q == PH_HS);
  assign ls_on = (ph_q == PH_LS);

  p_hs_after_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(ls_low));
  p_ls_after_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> $past(hs_low));
  p_idle_when_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || parked) |=> (!hs_on && !ls_on));
  p_uvlo_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (ph_q == PH_OFF));
  p_zero_cross_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && demu_en && zc) |=> !ls_on);
endmodule

// File: rtl/buck_gate_ctrl.sv
// Top: one-phase synchronous buck gate-drive sequencer.
module buck_gate_ctrl
  import buck_gd_pkg::*;
#(
  parameter int HOLD_CYC    = 8,
  parameter int DIS_OFF_CYC = 10,
  parameter int DIS_ON_CYC  = 25,
  parameter int DT_CYC      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       dis_n,
  input  logic       demu_n,
  input  logic       zc_flag,
  input  logic       uvlo,
  input  logic       hs_low_sense,
  input  logic       ls_low_sense,
  output logic       hs_gate,
  output logic       ls_gate
);
  logic run, parked, hs_on, ls_on;

  bgd_enable_filter #(.OFF_CYC(DIS_OFF_CYC), .ON_CYC(DIS_ON_CYC)) u_en (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .dis_n(dis_n), .run(run));

  bgd_tri_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .is_mid(pwm_lvl[1]), .parked(parked));

  bgd_phase_fsm #(.DT_CYC(DT_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .run(run), .parked(parked),
    .pwm_hi(pwm_lvl == LVL_HI), .pwm_lo(pwm_lvl == LVL_LO),
    .demu_en(!demu_n), .zc(zc_flag),
    .hs_low(hs_low_sense), .ls_low(ls_low_sense),
    .hs_on(hs_on), .ls_on(ls_on));

  // Lockout clamps in the same cycle, ahead of the registered phase
  assign hs_gate = hs_on & ~uvlo;
  assign ls_gate = ls_on & ~uvlo;

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
endmodule

// File: tb/buck_gate_ctrl_bench.sv
module buck_gate_ctrl_bench;
  localparam int HOLD = 8, DOFF = 10, DON = 25, DT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwm_lvl = 2'b00;
  logic dis_n = 1'b0, demu_n = 1'b1, zc_flag = 1'b0, uvlo = 1'b0;
  logic hs_low_sense, ls_low_sense, hs_gate, ls_gate;
  logic [1:0] hs_sh = 2'b11, ls_sh = 2'b11;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  buck_gate_ctrl #(.HOLD_CYC(HOLD), .DIS_OFF_CYC(DOFF), .DIS_ON_CYC(DON),
                   .DT_CYC(DT)) u_buck_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .dis_n(dis_n),
    .demu_n(demu_n), .zc_flag(zc_flag), .uvlo(uvlo),
    .hs_low_sense(hs_low_sense), .ls_low_sense(ls_low_sense),
    .hs_gate(hs_gate), .ls_gate(ls_gate));

  // Gate sense model: each flag trails the inverted gate by two half-cycle updates
  assign hs_low_sense = hs_sh[1];
  assign ls_low_sense = ls_sh[1];
  always @(negedge clk) begin
    hs_sh <= {hs_sh[0], ~hs_gate};
    ls_sh <= {ls_sh[0], ~ls_gate};
  end

  // Reference model: counters and a phase number (0 off,1 wait-hi,2 hi,3 wait-lo,4 lo,5 lo cut)
  int m_dcnt, m_run, m_mcnt, m_park, m_cmd, m_ph, m_dt, want, nph, ndt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_dcnt = 0; m_run = 0; m_mcnt = 0; m_park = 0; m_cmd = 0; m_ph = 0; m_dt = 0;
    end else begin
      if (m_run == 0 || m_park == 1) want = 0;
      else if (pwm_lvl == 2'b01) want = 1;
      else if (pwm_lvl == 2'b00) want = 2;
      else want = m_cmd;
      nph = m_ph; ndt = 0;
      if (want == 0) nph = 0;
      else if (want == 1) begin
        if (m_ph != 1 && m_ph != 2) nph = 1;
        else if (m_ph == 1 && ls_low_sense) begin
          if (m_dt + 1 >= DT) nph = 2; else ndt = m_dt + 1;
        end
      end else begin
        if (m_ph == 0 || m_ph == 1 || m_ph == 2) nph = 3;
        else if ((m_ph == 3 || m_ph == 4) && !demu_n && zc_flag) nph = 5;
        else if (m_ph == 3 && hs_low_sense) begin
          if (m_dt + 1 >= DT) nph = 4; else ndt = m_dt + 1;
        end
      end
      if (uvlo) begin nph = 0; ndt = 0; want = 0; end
      m_ph = nph; m_dt = ndt; m_cmd = want;
      if (pwm_lvl[1] == 1'b0) begin m_mcnt = 0; m_park = 0; end
      else if (m_park == 0) begin
        m_mcnt++;
        if (m_mcnt >= HOLD) begin m_park = 1; m_mcnt = 0; end
      end
      if (uvlo) begin m_run = 0; m_dcnt = 0; end
      else if (int'(dis_n) == m_run) m_dcnt = 0;
      else begin
        m_dcnt++;
        if (m_dcnt >= (m_run == 1 ? DOFF : DON)) begin m_run = 1 - m_run; m_dcnt = 0; end
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp_v, input string what);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp_v, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_tag, hs_gate, (m_ph == 2) && !uvlo, "model hs_gate");
      check(cur_tag, ls_gate, (m_ph == 4) && !uvlo, "model ls_gate");
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    check("R1", hs_gate, 1'b0, "hs in reset");
    check("R1", ls_gate, 1'b0, "ls in reset");
    rst_n = 1'b1; dis_n = 1'b1; pwm_lvl = 2'b00;
    // R7: start-up filter
    cur_tag = "R7";
    step(DON);
    check("R7", ls_gate, 1'b0, "ls before start-up filter");
    step(10);
    check("R9", ls_gate, 1'b1, "ls follows low pwm");
    // R9: zero crossing ignored without emulation
    cur_tag = "R9"; zc_flag = 1'b1; step(4);
    check("R9", ls_gate, 1'b1, "ls with zc, emulation off");
    zc_flag = 1'b0;
    // R2/R3: low to high transition with dead time
    cur_tag = "R2"; pwm_lvl = 2'b01; step(1);
    check("R2", ls_gate, 1'b0, "ls off after high");
    check("R2", hs_gate, 1'b0, "hs waits");
    step(2);
    check("R3", hs_gate, 1'b0, "hs still in dead time");
    step(1);
    check("R3", hs_gate, 1'b1, "hs on after dead time");
    // R5: short mid keeps state, long mid parks
    cur_tag = "R5"; pwm_lvl = 2'b10; step(HOLD - 1);
    pwm_lvl = 2'b01; step(2);
    check("R5", hs_gate, 1'b1, "short mid keeps hs");
    pwm_lvl = 2'b11; step(HOLD);
    check("R5", hs_gate, 1'b1, "hs on through hold-off");
    step(1);
    check("R5", hs_gate, 1'b0, "parked after hold-off");
    check("R5", ls_gate, 1'b0, "ls parked");
    pwm_lvl = 2'b01; step(8);
    check("R3", hs_gate, 1'b1, "exit park with high");
    // R6: disable filter
    cur_tag = "R6"; dis_n = 1'b0; step(DOFF);
    check("R6", hs_gate, 1'b1, "hs until disable filter");
    step(1);
    check("R6", hs_gate, 1'b0, "hs off after disable");
    pwm_lvl = 2'b00; step(6);
    check("R6", ls_gate, 1'b0, "ls held off while disabled");
    dis_n = 1'b1; step(DON - 3); dis_n = 1'b0; step(1); dis_n = 1'b1;
    cur_tag = "R7"; step(DON - 1);
    check("R7", ls_gate, 1'b0, "filter restarted by glitch");
    step(8);
    check("R7", ls_gate, 1'b1, "ls after resume");
    // R8: zero-crossing cut under emulation
    cur_tag = "R8"; demu_n = 1'b0; step(2);
    check("R8", ls_gate, 1'b1, "ls on before zc");
    zc_flag = 1'b1; step(1);
    check("R8", ls_gate, 1'b0, "ls cut at zc");
    zc_flag = 1'b0; step(5);
    check("R8", ls_gate, 1'b0, "ls stays cut");
    pwm_lvl = 2'b01; step(6); pwm_lvl = 2'b00; step(8);
    check("R8", ls_gate, 1'b1, "ls back after next high");
    demu_n = 1'b1;
    // R10: lockout clamp
    cur_tag = "R10"; uvlo = 1'b1; #1;
    check("R10", ls_gate, 1'b0, "clamp same cycle");
    step(3); uvlo = 1'b0; step(DON);
    check("R10", ls_gate, 1'b0, "start-up filter after lockout");
    step(10);
    check("R10", ls_gate, 1'b1, "resume after lockout");
    // R4: random traffic against the model
    cur_tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) pwm_lvl = 2'b01;
      else if (r < 16) pwm_lvl = 2'b00;
      else if (r < 19) pwm_lvl = 2'b10;
      if ($urandom_range(0, 99) < 10) zc_flag = ~zc_flag;
      if ($urandom_range(0, 299) == 0) demu_n = ~demu_n;
      if ($urandom_range(0, 499) == 0) dis_n = ~dis_n;
      if ($urandom_range(0, 99) < 5 && dis_n == 1'b0) dis_n = 1'b1;
      uvlo = ($urandom_range(0, 999) < 3);
      step(1);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule